// File: doc/BRIEF.md
# I2C Byte Transfer Sequencer

This block sits between a requester and a bit-level I2C controller. The requester hands it one byte-level request at a time. A request may ask for a START, a byte write or a byte read, and a STOP. For a read it also states whether the master answers with ACK or NACK. The sequencer expands the request into an ordered series of single-bit commands and hands them to the bit layer one at a time, waiting for each to complete.

Data moves through one shift register, most significant bit first. After a written byte, the sequencer gives up the data line for one bit and records the receiver's acknowledge. After a read byte, it drives the acknowledge bit the requester chose. Arbitration loss reported by the bit layer cancels the request at once. The block does not continue on its own after a NACK. The requester decides whether to stop, issue a repeated START or carry on. Both 7-bit and 10-bit addressing are formed by the requester as successive byte requests; the sequencer sends each byte unchanged.

Top module: `i2c_byte_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `bit_req`, `rx_ack_n` and `arb_lost` are 0, `rx_byte` is 0 and `cmd_ready` is 1.
- R2: A request is taken only when `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` is 1 only while idle and while `bit_arb_lost` is low. If both `cmd_write` and `cmd_read` are set, the write is performed and the read is dropped.
- R3: Bit command codes on `bit_cmd` are 0 none, 1 START, 2 STOP, 3 WRITE, 4 READ. When `cmd_start` is set, a START is the first bit command of the request.
- R4: A write issues eight WRITE commands whose `bit_din` carries `tx_byte` from bit 7 down to bit 0. It then issues one READ, and the `bit_dout` returned for that READ is stored in `rx_ack_n` (0 = ACK, 1 = NACK).
- R5: A read issues eight READ commands and assembles `rx_byte` from the returned `bit_dout` values, the first one landing in bit 7. It then issues one WRITE whose `bit_din` equals `cmd_nack` (0 = ACK, 1 = NACK).
- R6: When `cmd_stop` is set, a STOP is the last bit command of the request, whatever the acknowledge was. Nothing beyond the request is ever issued, so a NACK leaves the block idle.
- R7: `busy` is 1 from the cycle after acceptance until completion. `done` is a one-cycle pulse in the cycle `busy` falls.
- R8: `rx_ack_n` is cleared when a request is accepted and changes only on the acknowledge of a write. `rx_byte` changes only when a read byte completes.
- R9: `bit_cmd` and `bit_din` stay unchanged while `bit_req` is 1 and `bit_ack` has not yet been seen.
- R10: When `bit_arb_lost` is 1, the current request is dropped without a STOP, the block returns to idle with a `done` pulse, and `arb_lost` stays 1 until the next request is accepted.
- R11: 10-bit addressing works as successive requests. START plus a write of 11110 A9 A8 0 is followed by a write of A7..A0. A read then uses a repeated START with 11110 A9 A8 1. Each byte appears on the bit commands unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Request present |
| cmd_ready | output | 1 | Request can be taken |
| cmd_start | input | 1 | Begin with START (or repeated START) |
| cmd_stop | input | 1 | End with STOP |
| cmd_write | input | 1 | Send `tx_byte` |
| cmd_read | input | 1 | Receive one byte |
| cmd_nack | input | 1 | Acknowledge bit driven after a read (1 = NACK) |
| tx_byte | input | 8 | Byte to send |
| done | output | 1 | Request finished (one cycle) |
| busy | output | 1 | Request in progress |
| rx_byte | output | 8 | Last byte received |
| rx_ack_n | output | 1 | Acknowledge seen after last written byte (1 = NACK) |
| arb_lost | output | 1 | Arbitration lost during last request |
| bit_req | output | 1 | Bit command valid toward the bit layer |
| bit_cmd | output | 3 | Bit command code |
| bit_din | output | 1 | Data-line value for a WRITE bit command |
| bit_ack | input | 1 | Bit layer finished the current bit command |
| bit_dout | input | 1 | Data-line value sampled by the bit layer |
| bit_arb_lost | input | 1 | Arbitration loss from the bit layer |

## Verification
The sequencer runs through a 7-bit write transaction (address, data, STOP) and a 7-bit read transaction that ends with NACK and STOP. It also runs a 10-bit read built from two address writes, a repeated START and a final read. Bit patterns such as 0x5A, 0xA5, 0x3C, 0xC3 and 0x81 separate MSB-first ordering from reversed or shifted orderings. A NACK on a write shows that the acknowledge is stored and that the block stops on its own. Further requests carry both write and read set, carry only a STOP, or lose arbitration partway through a read that asked for a STOP. These show the request priority, the bare STOP case, and that abandoning a request emits no STOP and that the loss flag clears on the next request.

// File: rtl/i2c_byte_seq.sv
module i2c_byte_seq #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid,
  output logic         cmd_ready,
  input  logic         cmd_start,
  input  logic         cmd_stop,
  input  logic         cmd_write,
  input  logic         cmd_read,
  input  logic         cmd_nack,
  input  logic [W-1:0] tx_byte,
  output logic         done,
  output logic         busy,
  output logic [W-1:0] rx_byte,
  output logic         rx_ack_n,
  output logic         arb_lost,
  output logic         bit_req,
  output logic [2:0]   bit_cmd,
  output logic         bit_din,
  input  logic         bit_ack,
  input  logic         bit_dout,
  input  logic         bit_arb_lost
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);
  localparam logic [2:0] BC_NONE = 3'd0, BC_START = 3'd1, BC_STOP = 3'd2,
                         BC_WRITE = 3'd3, BC_READ = 3'd4;

  typedef enum logic [2:0] {S_IDLE, S_START, S_WR, S_RD, S_ACK, S_STOP} st_t;

  st_t           st;
  logic          f_stop, f_wr, f_rd, f_nack;
  logic [W-1:0]  sh;
  logic [CW-1:0] cnt;
  logic          accept;

  function automatic st_t phase_after_start(input logic wr, input logic rd, input logic stp);
    if (wr)       return S_WR;
    else if (rd)  return S_RD;
    else if (stp) return S_STOP;
    else          return S_IDLE;
  endfunction

  assign cmd_ready = (st == S_IDLE) && !bit_arb_lost;
  assign accept    = cmd_valid && cmd_ready;
  assign busy      = (st != S_IDLE);
  assign bit_req   = busy;

  always_comb begin
    bit_cmd = BC_NONE;
    bit_din = 1'b1;
    case (st)
      S_START: bit_cmd = BC_START;
      S_WR:    begin bit_cmd = BC_WRITE; bit_din = sh[W-1]; end
      S_RD:    bit_cmd = BC_READ;
      S_ACK:   if (f_rd) begin bit_cmd = BC_WRITE; bit_din = f_nack; end
               else bit_cmd = BC_READ;
      S_STOP:  bit_cmd = BC_STOP;
      default: bit_cmd = BC_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      f_stop <= 1'b0; f_wr <= 1'b0; f_rd <= 1'b0; f_nack <= 1'b0;
      sh <= '0; cnt <= '0;
      rx_byte <= '0; rx_ack_n <= 1'b0; arb_lost <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (bit_arb_lost) begin
        arb_lost <= 1'b1;
        if (st != S_IDLE) done <= 1'b1;
        st <= S_IDLE;
        f_stop <= 1'b0; f_wr <= 1'b0; f_rd <= 1'b0;
        cnt <= '0;
      end else if (accept) begin
        f_wr     <= cmd_write;
        f_rd     <= cmd_read && !cmd_write;
        f_stop   <= cmd_stop;
        f_nack   <= cmd_nack;
        sh       <= tx_byte;
        cnt      <= '0;
        rx_ack_n <= 1'b0;
        arb_lost <= 1'b0;
        if (cmd_start) st <= S_START;
        else begin
          st <= phase_after_start(cmd_write, cmd_read, cmd_stop);
          if (!cmd_write && !cmd_read && !cmd_stop) done <= 1'b1;
        end
      end else if (bit_ack && st != S_IDLE) begin
        case (st)
          S_START: begin
            st <= phase_after_start(f_wr, f_rd, f_stop);
            if (!f_wr && !f_rd && !f_stop) done <= 1'b1;
          end
          S_WR: begin
            sh <= {sh[W-2:0], 1'b0};
            if (cnt == LAST) begin cnt <= '0; st <= S_ACK; end
            else cnt <= cnt + 1'b1;
          end
          S_RD: begin
            sh <= {sh[W-2:0], bit_dout};
            if (cnt == LAST) begin
              cnt <= '0;
              rx_byte <= {sh[W-2:0], bit_dout};
              st <= S_ACK;
            end else cnt <= cnt + 1'b1;
          end
          S_ACK: begin
            if (f_wr) rx_ack_n <= bit_dout;
            if (f_stop) st <= S_STOP;
            else begin st <= S_IDLE; done <= 1'b1; end
          end
          S_STOP: begin
            st <= S_IDLE;
            f_stop <= 1'b0;
            done <= 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assert_hold_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_req && !bit_ack && !bit_arb_lost) |=> (bit_req && $stable(bit_cmd) && $stable(bit_din)));

  assert_ack_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !rx_ack_n);

  assert_rx_only_on_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_byte) |-> $past(bit_cmd == BC_READ && bit_ack));

  assert_done_on_finish_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_arb_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_lost) |-> !bit_req);

  assert_ready_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !busy);
endmodule

// File: tb/i2c_byte_seq_test.sv
module i2c_byte_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 0, cmd_start = 0, cmd_stop = 0, cmd_write = 0, cmd_read = 0, cmd_nack = 0;
  logic [7:0] tx_byte = '0;
  logic bit_ack = 0, bit_dout = 1, bit_arb_lost = 0;
  logic cmd_ready, done, busy, rx_ack_n, arb_lost, bit_req, bit_din;
  logic [7:0] rx_byte;
  logic [2:0] bit_cmd;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [2:0] log_cmd [32];
  logic       log_din [32];
  int log_n;
  bit got_done;

  always #5 clk = ~clk;

  i2c_byte_seq uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_write(cmd_write), .cmd_read(cmd_read),
    .cmd_nack(cmd_nack), .tx_byte(tx_byte), .done(done), .busy(busy), .rx_byte(rx_byte),
    .rx_ack_n(rx_ack_n), .arb_lost(arb_lost), .bit_req(bit_req), .bit_cmd(bit_cmd),
    .bit_din(bit_din), .bit_ack(bit_ack), .bit_dout(bit_dout), .bit_arb_lost(bit_arb_lost)
  );

  // {start, stop, write, read, nack, tx[8], resp[9], exp_rx[8], exp_ack_n}
  localparam logic [30:0] VEC [12] = '{
    {5'b10100, 8'hA0, 9'h000, 8'h00, 1'b0},
    {5'b00100, 8'h3C, 9'h100, 8'h00, 1'b1},
    {5'b01100, 8'hC3, 9'h000, 8'h00, 1'b0},
    {5'b10100, 8'hA1, 9'h000, 8'h00, 1'b0},
    {5'b00010, 8'h00, 9'h0B4, 8'h5A, 1'b0},
    {5'b01011, 8'h00, 9'h14A, 8'hA5, 1'b0},
    {5'b10100, 8'hF2, 9'h000, 8'hA5, 1'b0},
    {5'b00100, 8'h7E, 9'h000, 8'hA5, 1'b0},
    {5'b10100, 8'hF3, 9'h000, 8'hA5, 1'b0},
    {5'b01011, 8'h00, 9'h1FE, 8'hFF, 1'b0},
    {5'b00110, 8'h81, 9'h100, 8'hFF, 1'b1},
    {5'b01000, 8'h00, 9'h000, 8'hFF, 1'b0}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic run(input logic s, input logic p, input logic w, input logic r, input logic n,
                     input logic [7:0] tx, input logic [8:0] resp, input int arb_at);
    int rd_i = 0;
    log_n = 0;
    got_done = 0;
    @(negedge clk);
    cmd_start = s; cmd_stop = p; cmd_write = w; cmd_read = r; cmd_nack = n; tx_byte = tx;
    cmd_valid = 1'b1;
    for (int g = 0; g < 300 && !got_done; g++) begin
      @(negedge clk);
      cmd_valid = 1'b0;
      bit_arb_lost = 1'b0;
      if (done) got_done = 1;
      if (bit_ack) bit_ack = 1'b0;
      else if (bit_req) begin
        if (log_n < 32) begin log_cmd[log_n] = bit_cmd; log_din[log_n] = bit_din; end
        if (log_n == arb_at) bit_arb_lost = 1'b1;
        else begin
          bit_ack = 1'b1;
          if (bit_cmd == 3'd4) begin bit_dout = (rd_i < 9) ? resp[8 - rd_i] : 1'b1; rd_i++; end
          else bit_dout = 1'b1;
        end
        log_n++;
      end
    end
    check(got_done, "R7 done not seen", 0, 1);
  endtask

  task automatic check_seq(input logic s, input logic p, input logic w, input logic r,
                           input logic n, input logic [7:0] tx, input int idx);
    logic [2:0] ec [32];
    logic       ed [32];
    int k = 0;
    bit ok = 1;
    if (s) begin ec[k] = 3'd1; ed[k] = 1'b1; k++; end
    if (w) begin
      for (int b = 7; b >= 0; b--) begin ec[k] = 3'd3; ed[k] = tx[b]; k++; end
      ec[k] = 3'd4; ed[k] = 1'b1; k++;
    end else if (r) begin
      for (int b = 0; b < 8; b++) begin ec[k] = 3'd4; ed[k] = 1'b1; k++; end
      ec[k] = 3'd3; ed[k] = n; k++;
    end
    if (p) begin ec[k] = 3'd2; ed[k] = 1'b1; k++; end
    if (log_n != k) ok = 0;
    else
      for (int i = 0; i < k; i++)
        if (log_cmd[i] != ec[i] || (ec[i] == 3'd3 && log_din[i] != ed[i])) ok = 0;
    check(ok, $sformatf("R3 R4 R5 R6 R11 bit sequence vec %0d (count)", idx), log_n, k);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !bit_req && cmd_ready, "R1 idle after reset", {busy, done, bit_req, cmd_ready}, 4'b0001);
    check(rx_byte == 8'h00 && !rx_ack_n && !arb_lost, "R1 outputs after reset", {rx_byte, rx_ack_n, arb_lost}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && cmd_ready, "R1 idle after release", busy, 0);

    for (int v = 0; v < 12; v++) begin
      logic [30:0] e;
      e = VEC[v];
      run(e[30], e[29], e[28], e[27], e[26], e[25:18], e[17:9], -1);
      check(rx_byte == e[8:1], $sformatf("R5 R8 rx_byte vec %0d", v), rx_byte, e[8:1]);
      check(rx_ack_n == e[0], $sformatf("R4 R8 rx_ack_n vec %0d", v), rx_ack_n, e[0]);
      check(!busy && !bit_req && !arb_lost, $sformatf("R6 R7 idle at done vec %0d", v), {busy, bit_req, arb_lost}, 0);
      check_seq(e[30], e[29], e[28], e[27] && !e[28], e[26], e[25:18], v);
      @(negedge clk);
      check(!done, $sformatf("R7 done one cycle vec %0d", v), done, 0);
    end

    // R10: arbitration lost during a read that asked for STOP
    run(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h00, 9'h1FE, 3);
    check(arb_lost, "R10 arb_lost latched", arb_lost, 1);
    check(!busy && !bit_req, "R10 returns to idle", {busy, bit_req}, 0);
    check(log_n == 4, "R10 no further bit commands", log_n, 4);
    check(rx_byte == 8'hFF, "R8 R10 rx_byte untouched by aborted read", rx_byte, 8'hFF);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (bit_req) check(0, "R10 no STOP after arb loss", bit_req, 0);
    end
    check(!bit_req && arb_lost, "R10 stays idle with flag held", {bit_req, arb_lost}, 2'b01);

    run(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 9'h000, -1);
    check(!arb_lost, "R2 R10 arb_lost cleared on accept", arb_lost, 0);
    check(log_n == 1 && log_cmd[0] == 3'd2, "R6 stop-only request", log_cmd[0], 2);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule